// File: doc/BRIEF.md
# Sound Coprocessor Bus-Borrow and Bank Bridge

This block sits next to a 16-bit host processor and mediates its access to the private bus of an 8-bit sound coprocessor. It provides two control registers in host address space. The first is a bus-borrow register: setting it stops the coprocessor and hands its RAM to the host. The second is a hold-in-reset register. The block decodes host accesses to a mirrored 8 KB coprocessor RAM window. It lets a write through to the RAM port only when the host owns the bus and the coprocessor is out of reset. Any other write to that window is dropped and flagged.

The block also keeps a 9-bit bank register that the coprocessor uses to choose which 32 KB slice of host space it sees. The register is loaded one bit per host write, with each new bit entering at the top. Reading the bus-borrow address returns a status byte in the upper half and a wrapping access counter in the lower half. RAM bytes read by the host appear in both halves of the 16-bit result.

Top module: `sndbus_bridge`

## Requirements
- R1: After reset, `cop_reset` is 1, `cop_run` is 0, `bank_base` is 0, `anomaly` and `snd_reset_pulse` are 0, and a read of 0xA11100 returns 0x8100.
- R2: A write to 0xA11100 takes the control bit (bit 8 of `host_wdata` for a word access, bit 0 for a byte access). A 1 makes the host own the bus and a 0 releases it, effective on the edge after the strobe.
- R3: A read of 0xA11100 places a status byte in bits 15:8. Bit 15 is always 1. Bit 8 is 0 only while the host owns the bus and the coprocessor is out of reset. All other status bits are 0.
- R4: Bits 7:0 of a 0xA11100 read hold a counter that starts at 0 and advances by one, wrapping from 255 to 0, after every read of that address. No other access changes it.
- R5: A write to 0xA11200 takes the control bit the same way as R2. A 0 asserts `cop_reset` and a 1 releases it. `cop_run` is 1 exactly when the bus is not owned by the host and reset is released.
- R6: When a 0xA11200 write changes the reset state, `snd_reset_pulse` is 1 for one cycle after the edge. A write that leaves the state unchanged gives no pulse.
- R7: A write to an address whose bits 23:16 are 0xA0 and whose bit 14 is 0 drives `ram_addr` with address bits 12:0 in the strobe cycle. `ram_we` is 1 only if the host owns the bus and reset is released. A word write stores `host_wdata[15:8]`; a byte write stores `host_wdata[7:0]`.
- R8: A RAM-window write that is not allowed leaves `ram_we` at 0, and `anomaly` is 1 for the one cycle after the edge. Allowed writes raise no flag.
- R9: A read in the RAM window returns the RAM byte in both bits 15:8 and bits 7:0, for byte and word reads alike.
- R10: A write to any address with (address AND 0xFF7F00) equal to 0xA06000 shifts the 9-bit bank register right by one and loads `host_wdata[0]` into bit 8. `bank_base` equals the register shifted left by 15.
- R11: A read at bits 23:16 = 0xA0 outside the RAM window returns 0xFFFF. A read of any address outside that region other than 0xA11100 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_addr | input | 24 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid in the strobe cycle |
| ram_addr | output | 13 | Coprocessor RAM address |
| ram_we | output | 1 | Coprocessor RAM write enable |
| ram_wdata | output | 8 | Coprocessor RAM write byte |
| ram_rdata | input | 8 | Coprocessor RAM read byte (asynchronous) |
| cop_run | output | 1 | Coprocessor may execute |
| cop_reset | output | 1 | Coprocessor held in reset |
| snd_reset_pulse | output | 1 | One-cycle reset to sound and timer logic |
| bank_base | output | 24 | Host base address of the coprocessor's window |
| anomaly | output | 1 | One-cycle flag for a dropped RAM write |

## Verification
RAM-window writes are issued under all four combinations of bus ownership and reset. These cases separate the gating term for the bus from the gating term for reset, and both from the anomaly flag. Byte and word writes carry different values in the two data lanes. This shows which lane is stored and which lane drives each control bit. A mirror address shows that only 13 address bits reach the RAM. The bank register is fed an irregular nine-bit pattern through two mirror addresses, which exposes the shift direction and the entry point. Reads cover the status, counter, unmapped and outside-region cases, and the counter is driven through a full wrap.

// File: rtl/sndbus_pkg.sv
package sndbus_pkg;
  localparam int DW = 16;
  localparam int BW = 8;

  // Control bit sits in the upper lane for word accesses, lower lane for bytes.
  function automatic logic ctl_bit(input logic word, input logic [DW-1:0] wd);
    return word ? wd[BW] : wd[0];
  endfunction

  // Byte stored into coprocessor RAM.
  function automatic logic [BW-1:0] store_byte(input logic word, input logic [DW-1:0] wd);
    return word ? wd[DW-1:BW] : wd[BW-1:0];
  endfunction

  function automatic logic [DW-1:0] mirror(input logic [BW-1:0] b);
    return {b, b};
  endfunction

  // Bit 7 fixed high; bit 0 low only while host owns bus and core is out of reset.
  function automatic logic [BW-1:0] status_byte(input logic held, input logic in_rst);
    return {1'b1, 6'b0, (~held) | in_rst};
  endfunction
endpackage

// File: rtl/sndbus_decode.sv
module sndbus_decode #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] REGION_MASK = 24'hFF0000,
  parameter logic [ADDR_W-1:0] REGION_BASE = 24'hA00000,
  parameter logic [ADDR_W-1:0] RAM_MASK    = 24'hFF4000,
  parameter logic [ADDR_W-1:0] BANK_MASK   = 24'hFF7F00,
  parameter logic [ADDR_W-1:0] BANK_MATCH  = 24'hA06000,
  parameter logic [ADDR_W-1:0] BUSREQ_ADDR = 24'hA11100,
  parameter logic [ADDR_W-1:0] RSTCTL_ADDR = 24'hA11200
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_region,
  output logic              hit_ram,
  output logic              hit_bank,
  output logic              hit_busreq,
  output logic              hit_rstctl
);
  always_comb begin
    hit_region = (addr & REGION_MASK) == REGION_BASE;
    hit_ram    = (addr & RAM_MASK) == REGION_BASE;
    hit_bank   = (addr & BANK_MASK) == BANK_MATCH;
    hit_busreq = addr == BUSREQ_ADDR;
    hit_rstctl = addr == RSTCTL_ADDR;
  end
endmodule

// File: rtl/sndbus_ctrl.sv
module sndbus_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_busreq,
  input  logic             wr_rstctl,
  input  logic             rd_busreq,
  input  logic             wbit,
  output logic             bus_held,
  output logic             in_reset,
  output logic             snd_pulse,
  output logic [CNT_W-1:0] rd_count
);
  logic next_rst;
  assign next_rst = ~wbit;   // written 0 holds the core in reset

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_held  <= 1'b0;
      in_reset  <= 1'b1;
      snd_pulse <= 1'b0;
      rd_count  <= '0;
    end else begin
      snd_pulse <= 1'b0;
      if (wr_busreq) bus_held <= wbit;
      if (wr_rstctl) begin
        in_reset  <= next_rst;
        snd_pulse <= next_rst != in_reset;
      end
      if (rd_busreq) rd_count <= rd_count + 1'b1;
    end
  end
endmodule

// File: rtl/sndbus_bank.sv
module sndbus_bank #(
  parameter int ADDR_W    = 24,
  parameter int BANK_W    = 9,
  parameter int WIN_SHIFT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              din,
  output logic [BANK_W-1:0] bank_q,
  output logic [ADDR_W-1:0] base
);
  localparam int SPAN = BANK_W + WIN_SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) bank_q <= '0;
    else if (wr) bank_q <= {din, bank_q[BANK_W-1:1]};
  end

  generate
    if (SPAN <= ADDR_W) begin : g_fit
      assign base = ADDR_W'(bank_q) << WIN_SHIFT;
    end else begin : g_trunc
      logic [SPAN-1:0] wide;
      assign wide = SPAN'(bank_q) << WIN_SHIFT;
      assign base = wide[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/sndbus_ramgate.sv
module sndbus_ramgate #(
  parameter int RAM_AW = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_req,
  input  logic                     allow,
  input  logic                     word,
  input  logic [sndbus_pkg::DW-1:0] wdata,
  input  logic [RAM_AW-1:0]        addr_lo,
  output logic [RAM_AW-1:0]        ram_addr,
  output logic                     ram_we,
  output logic [sndbus_pkg::BW-1:0] ram_wdata,
  output logic                     ev_ok,
  output logic                     ev_drop,
  output logic                     anomaly
);
  assign ev_ok     = wr_req & allow;
  assign ev_drop   = wr_req & ~allow;
  assign ram_we    = ev_ok;
  assign ram_addr  = addr_lo;
  assign ram_wdata = sndbus_pkg::store_byte(word, wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) anomaly <= 1'b0;
    else        anomaly <= ev_drop;
  end
endmodule

// File: rtl/sndbus_bridge.sv
module sndbus_bridge #(
  parameter int ADDR_W    = 24,
  parameter int RAM_AW    = 13,
  parameter int BANK_W    = 9,
  parameter int WIN_SHIFT = 15,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic              host_word,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              cop_run,
  output logic              cop_reset,
  output logic              snd_reset_pulse,
  output logic [ADDR_W-1:0] bank_base,
  output logic              anomaly
);
  import sndbus_pkg::*;

  logic hit_region, hit_ram, hit_bank, hit_busreq, hit_rstctl;
  logic wr_cyc, rd_cyc;
  logic ev_busreq_wr, ev_rstctl_wr, ev_bank_wr, ev_busreq_rd;
  logic ev_ram_ok, ev_ram_drop;
  logic ctl_b, bus_held, in_reset;
  logic [CNT_W-1:0]  rd_count;
  logic [BANK_W-1:0] bank_q;

  sndbus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(host_addr), .hit_region(hit_region), .hit_ram(hit_ram),
    .hit_bank(hit_bank), .hit_busreq(hit_busreq), .hit_rstctl(hit_rstctl)
  );

  assign wr_cyc       = host_sel & host_we;
  assign rd_cyc       = host_sel & ~host_we;
  assign ev_busreq_wr = wr_cyc & hit_busreq;
  assign ev_rstctl_wr = wr_cyc & hit_rstctl;
  assign ev_bank_wr   = wr_cyc & hit_bank;
  assign ev_busreq_rd = rd_cyc & hit_busreq;
  assign ctl_b        = ctl_bit(host_word, host_wdata);

  sndbus_ctrl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_busreq(ev_busreq_wr), .wr_rstctl(ev_rstctl_wr),
    .rd_busreq(ev_busreq_rd), .wbit(ctl_b), .bus_held(bus_held),
    .in_reset(in_reset), .snd_pulse(snd_reset_pulse), .rd_count(rd_count)
  );

  sndbus_bank #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .WIN_SHIFT(WIN_SHIFT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(ev_bank_wr), .din(host_wdata[0]),
    .bank_q(bank_q), .base(bank_base)
  );

  sndbus_ramgate #(.RAM_AW(RAM_AW)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_cyc & hit_ram),
    .allow(bus_held & ~in_reset), .word(host_word), .wdata(host_wdata),
    .addr_lo(host_addr[RAM_AW-1:0]), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ev_ok(ev_ram_ok), .ev_drop(ev_ram_drop), .anomaly(anomaly)
  );

  assign cop_reset = in_reset;
  assign cop_run   = ~bus_held & ~in_reset;

  always_comb begin
    host_rdata = '0;
    if (rd_cyc) begin
      if (hit_busreq)      host_rdata = {status_byte(bus_held, in_reset), 8'(rd_count)};
      else if (hit_ram)    host_rdata = mirror(ram_rdata);
      else if (hit_region) host_rdata = 16'hFFFF;
    end
  end
endmodule

// File: rtl/sndbus_chk.sv
module sndbus_chk #(
  parameter int BANK_W = 9,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       host_rdata,
  input logic [15:0]       host_wdata,
  input logic              ram_we,
  input logic              cop_run,
  input logic              cop_reset,
  input logic              snd_reset_pulse,
  input logic              anomaly,
  input logic              ev_busreq_rd,
  input logic              ev_bank_wr,
  input logic              ev_ram_drop,
  input logic [CNT_W-1:0]  rd_count,
  input logic [BANK_W-1:0] bank_q
);
  assert_ram_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (!cop_reset && !cop_run));
  assert_drop_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ram_drop |=> anomaly);
  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    anomaly |-> $past(ev_ram_drop));
  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busreq_rd |=> rd_count == CNT_W'($past(rd_count) + 1'b1));
  assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_busreq_rd |=> $stable(rd_count));
  assert_status_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busreq_rd |-> host_rdata[15]);
  assert_pulse_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snd_reset_pulse |-> (cop_reset != $past(cop_reset)));
  assert_run_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cop_reset |-> !cop_run);
  assert_bank_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bank_wr |=> bank_q == {$past(host_wdata[0]), $past(bank_q[BANK_W-1:1])});
endmodule

bind sndbus_bridge sndbus_chk #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rdata(host_rdata), .host_wdata(host_wdata),
  .ram_we(ram_we), .cop_run(cop_run), .cop_reset(cop_reset),
  .snd_reset_pulse(snd_reset_pulse), .anomaly(anomaly),
  .ev_busreq_rd(ev_busreq_rd), .ev_bank_wr(ev_bank_wr), .ev_ram_drop(ev_ram_drop),
  .rd_count(rd_count), .bank_q(bank_q)
);

// File: tb/sim_sndbus_bridge.sv
module sim_sndbus_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 1'b0, host_we = 1'b0, host_word = 1'b0;
  logic [23:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [12:0] ram_addr;
  logic ram_we;
  logic [7:0] ram_wdata, ram_rdata;
  logic cop_run, cop_reset, snd_reset_pulse, anomaly;
  logic [23:0] bank_base;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mem [0:8191];
  logic [7:0] cnt_m = 8'd0;
  logic [8:0] bank_m = 9'd0;
  // captured in strobe cycle
  logic [15:0] cap_rd;
  logic cap_we;
  logic [12:0] cap_addr;
  logic [7:0] cap_wd;

  always #5 clk = ~clk;

  sndbus_bridge u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_word(host_word), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .cop_run(cop_run),
    .cop_reset(cop_reset), .snd_reset_pulse(snd_reset_pulse),
    .bank_base(bank_base), .anomaly(anomaly)
  );

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one host access; after return, registered effects are visible
  task automatic acc(input logic we, input logic word, input logic [23:0] a, input logic [15:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = we; host_word = word; host_addr = a; host_wdata = d;
    #1;
    cap_rd = host_rdata; cap_we = ram_we; cap_addr = ram_addr; cap_wd = ram_wdata;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic read_status(input string req, input logic [7:0] st);
    acc(1'b0, 1'b1, 24'hA11100, 16'h0);
    chk(req, cap_rd, {st, cnt_m});
    cnt_m = cnt_m + 8'd1;
  endtask

  task automatic t_reset_state();
    chk("R1 cop_reset", cop_reset, 1);
    chk("R1 cop_run", cop_run, 0);
    chk("R1 bank_base", bank_base, 0);
    chk("R1 anomaly", anomaly, 0);
    chk("R1 snd pulse", snd_reset_pulse, 0);
    read_status("R1 first status read", 8'h81);
    read_status("R4 counter step", 8'h81);
  endtask

  task automatic t_gating();
    // released bus, in reset: dropped
    acc(1'b1, 1'b0, 24'hA00010, 16'h0011);
    chk("R8 no we (released,reset)", cap_we, 0);
    chk("R8 anomaly", anomaly, 1);
    // take bus via byte lane
    acc(1'b1, 1'b0, 24'hA11100, 16'hFE01);
    chk("R2 byte take: run", cop_run, 0);
    read_status("R3 held but in reset", 8'h81);
    acc(1'b1, 1'b0, 24'hA00010, 16'h0022);
    chk("R8 no we (held,reset)", cap_we, 0);
    chk("R8 anomaly held/reset", anomaly, 1);
    // release reset by word lane
    acc(1'b1, 1'b1, 24'hA11200, 16'h01FE);
    chk("R5 reset released", cop_reset, 0);
    chk("R6 pulse on change", snd_reset_pulse, 1);
    chk("R5 run while held", cop_run, 0);
    read_status("R3 granted", 8'h80);
    acc(1'b1, 1'b1, 24'hA11200, 16'h0100);
    chk("R6 no pulse on same value", snd_reset_pulse, 0);
    // allowed writes
    acc(1'b1, 1'b0, 24'hA00010, 16'hA55A);
    chk("R7 byte we", cap_we, 1);
    chk("R7 byte addr", cap_addr, 13'h0010);
    chk("R7 byte lane", cap_wd, 8'h5A);
    chk("R8 no flag when allowed", anomaly, 0);
    acc(1'b1, 1'b1, 24'hA02002, 16'hC33C);
    chk("R7 word addr mirror", cap_addr, 13'h0002);
    chk("R7 word upper lane", cap_wd, 8'hC3);
    acc(1'b0, 1'b0, 24'hA00010, 16'h0);
    chk("R9 byte read mirrored", cap_rd, 16'h5A5A);
    acc(1'b0, 1'b1, 24'hA00002, 16'h0);
    chk("R9 word read mirrored", cap_rd, 16'hC3C3);
    // release bus via byte lane with upper lane set to show lane choice
    acc(1'b1, 1'b0, 24'hA11100, 16'h01FE);
    chk("R2 release", cop_run, 1);
    read_status("R3 running", 8'h81);
    acc(1'b1, 1'b0, 24'hA00010, 16'h0077);
    chk("R8 no we (released,out of reset)", cap_we, 0);
    chk("R8 anomaly running", anomaly, 1);
    acc(1'b0, 1'b0, 24'hA00010, 16'h0);
    chk("R8 RAM unchanged", cap_rd, 16'h5A5A);
    // word take, then assert reset
    acc(1'b1, 1'b1, 24'hA11100, 16'h01FE);
    chk("R2 word take", cop_run, 0);
    acc(1'b1, 1'b0, 24'hA11200, 16'hFFFE);
    chk("R5 reset asserted", cop_reset, 1);
    chk("R6 pulse on assert", snd_reset_pulse, 1);
    acc(1'b1, 1'b0, 24'hA00020, 16'h0033);
    chk("R8 no we (held,reset again)", cap_we, 0);
  endtask

  task automatic t_bank();
    logic [8:0] pat = 9'b101001101;
    for (int i = 0; i < 9; i++) begin
      acc(1'b1, 1'b1, (i % 2 == 0) ? 24'hA06000 : 24'hA0E0FF, {15'h7FFF ^ 15'(i), pat[i]});
      bank_m = (bank_m >> 1) | (9'(pat[i]) << 8);
      chk("R10 bank base", bank_base, 24'(bank_m) << 15);
    end
    acc(1'b1, 1'b0, 24'hA06100, 16'h0001);
    chk("R10 non-matching address", bank_base, 24'(bank_m) << 15);
  endtask

  task automatic t_reads();
    acc(1'b0, 1'b1, 24'hA04000, 16'h0);
    chk("R11 region unmapped 4000", cap_rd, 16'hFFFF);
    acc(1'b0, 1'b1, 24'hA0C000, 16'h0);
    chk("R11 region unmapped C000", cap_rd, 16'hFFFF);
    acc(1'b0, 1'b1, 24'hA06000, 16'h0);
    chk("R11 bank address read", cap_rd, 16'hFFFF);
    acc(1'b0, 1'b1, 24'hA11200, 16'h0);
    chk("R11 reset reg read", cap_rd, 16'h0000);
    acc(1'b0, 1'b1, 24'h123456, 16'h0);
    chk("R11 outside read", cap_rd, 16'h0000);
    read_status("R4 counter unaffected by other reads", 8'h81);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 260; i++) read_status("R4 counter wrap", 8'h81);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_gating();
    t_bank();
    t_reads();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule